// File: doc/BRIEF.md
# Filtered Branch Trace Buffer

This block keeps a short history of taken control transfers for a debug host. Each cycle the core may present one branch with its source address, its destination address, a two-bit kind tag and two drop flags. A filter decides whether the branch is kept, using three independent enable inputs, one for each branch kind. Kept branches go into an eight-slot circular store. The host pops entries oldest first through a read port and can see how many entries are valid.

A control state machine selects how the store is used. In **WRAP** (continuous mode off) the store runs freely and overwrites its oldest entry once it is full. Raising the continuous-mode input moves the machine from WRAP to **FILL** and empties the store. In FILL, storing the eighth entry moves the machine to **DRAIN**, where the stall request is raised and no further branches are recorded. When the host pops the last entry, DRAIN goes back to FILL if fewer than four fills have completed, or on to **HALT** after the fourth fill, giving 32 records in total. In HALT nothing more is recorded. Lowering the continuous-mode input returns every state to WRAP.

Top module: `bt_trace_top`

## Requirements
- R1: The store holds up to eight source/destination/kind records. The read port always shows the oldest valid record. A pop (`rd_pop` high while `entry_count` is non-zero) removes that record at the clock edge.
- R2: A branch is recorded only if `br_valid` is high and its kind is enabled. Kind 0 (normal branch) needs `keep_normal`, kind 1 (subroutine call or return) needs `keep_call`, kind 2 (exception or interrupt entry, or return from exception) needs `keep_exc`. Kind 3 is never recorded.
- R3: A branch with `br_zero_disp` high (a conditional branch with zero displacement) is never recorded.
- R4: A branch with `br_from_reset` high (the jump to the reset address) is never recorded.
- R5: In WRAP, a recorded branch that arrives while eight entries are held replaces the oldest one, and the count stays at eight.
- R6: `entry_count` gives the number of valid entries (0 to 8). After reset it is 0, and `stall_req` and `capture_done` are low.
- R7: The cycle in which continuous mode is entered from WRAP empties the store and discards any branch presented in that cycle.
- R8: In continuous mode, `stall_req` is high from the edge that stores the eighth entry. While it is high, presented branches are not recorded.
- R9: `stall_req` falls at the edge of the pop that empties the store. After a fill other than the fourth, recording then resumes.
- R10: Once the fourth fill has been drained, `capture_done` is high, `stall_req` is low and no branch is recorded.
- R11: Lowering `cont_en` returns the block to WRAP, where recording with overwrite resumes. A later entry into continuous mode again allows four fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_valid | input | 1 | A taken branch is presented this cycle |
| br_src | input | ADDR_W | Branch source address |
| br_dst | input | ADDR_W | Branch destination address |
| br_kind | input | 2 | 0 normal, 1 call/return, 2 exception, 3 none |
| br_zero_disp | input | 1 | Conditional branch with zero displacement |
| br_from_reset | input | 1 | Jump to the reset address after reset |
| keep_normal | input | 1 | Enable recording of kind 0 |
| keep_call | input | 1 | Enable recording of kind 1 |
| keep_exc | input | 1 | Enable recording of kind 2 |
| cont_en | input | 1 | Continuous (stall-and-drain) mode |
| rd_pop | input | 1 | Remove the oldest entry |
| rd_src | output | ADDR_W | Source address of the oldest entry |
| rd_dst | output | ADDR_W | Destination address of the oldest entry |
| rd_kind | output | 2 | Kind of the oldest entry |
| entry_count | output | $clog2(DEPTH+1) | Number of valid entries |
| stall_req | output | 1 | Request to stop the core until drained |
| capture_done | output | 1 | Four fills completed in continuous mode |

## Verification
The filter is swept over all eight enable masks crossed with all four kinds and both drop flags. After each step the count shows whether that one combination was kept. The store is then drained, so the readout confirms oldest-first ordering for many different record mixes. A run of thirteen branches in WRAP separates overwrite-oldest behaviour from overwrite-newest and from refusal. A full four-fill continuous session, with branches offered while stalled and after completion, separates the stall-rise, stall-release and halt transitions from off-by-one fill counting.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef enum logic [1:0] {
        K_NORMAL = 2'd0,
        K_CALL   = 2'd1,
        K_EXC    = 2'd2,
        K_NONE   = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        ST_WRAP,
        ST_FILL,
        ST_DRAIN,
        ST_HALT
    } cap_state_e;

endpackage

// File: rtl/bt_filter.sv
module bt_filter
    import bt_pkg::*;
(
    input  logic       valid,
    input  logic [1:0] kind,
    input  logic       zero_disp,
    input  logic       from_reset,
    input  logic       keep_normal,
    input  logic       keep_call,
    input  logic       keep_exc,
    output logic       hit
);
    logic kind_on;

    always_comb begin
        unique case (br_kind_e'(kind))
            K_NORMAL: kind_on = keep_normal;
            K_CALL:   kind_on = keep_call;
            K_EXC:    kind_on = keep_exc;
            default:  kind_on = 1'b0;
        endcase
        hit = valid && kind_on && !zero_disp && !from_reset;
    end
endmodule

// File: rtl/bt_ring.sv
module bt_ring #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       push,
    input  logic                       pop,
    input  logic                       allow_over,
    input  logic [ADDR_W-1:0]          wr_src,
    input  logic [ADDR_W-1:0]          wr_dst,
    input  logic [1:0]                 wr_kind,
    output logic [ADDR_W-1:0]          rd_src,
    output logic [ADDR_W-1:0]          rd_dst,
    output logic [1:0]                 rd_kind,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    logic [ADDR_W-1:0] src_mem  [DEPTH];
    logic [ADDR_W-1:0] dst_mem  [DEPTH];
    logic [1:0]        kind_mem [DEPTH];
    logic [PW-1:0]     head_q, tail_q;

    logic full, empty, do_pop, do_push, overwrite;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full      = (count == FULL_CNT);
        empty     = (count == '0);
        do_pop    = pop && !empty;
        do_push   = push && (!full || allow_over || do_pop);
        overwrite = do_push && full && !do_pop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                src_mem[i]  <= '0;
                dst_mem[i]  <= '0;
                kind_mem[i] <= '0;
            end
        end else if (clear) begin
            head_q <= '0;
            tail_q <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                src_mem[tail_q]  <= wr_src;
                dst_mem[tail_q]  <= wr_dst;
                kind_mem[tail_q] <= wr_kind;
                tail_q           <= bump(tail_q);
            end
            if (do_pop || overwrite) begin
                head_q <= bump(head_q);
            end
            if (do_push && !overwrite && !do_pop) begin
                count <= count + 1'b1;
            end else if (do_pop && !do_push) begin
                count <= count - 1'b1;
            end
        end
    end

    assign rd_src  = src_mem[head_q];
    assign rd_dst  = dst_mem[head_q];
    assign rd_kind = kind_mem[head_q];
endmodule

// File: rtl/bt_ctrl.sv
module bt_ctrl
    import bt_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int FILLS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cont_en,
    input  logic                       hit,
    input  logic                       rd_pop,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       push,
    output logic                       clear,
    output logic                       allow_over,
    output logic                       stall_req,
    output logic                       capture_done
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int FW = $clog2(FILLS + 1);
    localparam logic [CW-1:0] NEAR_FULL = CW'(DEPTH - 1);
    localparam logic [CW-1:0] ONE_LEFT  = CW'(1);
    localparam logic [FW-1:0] LAST_FILL = FW'(FILLS);

    cap_state_e state_q, state_d;
    logic [FW-1:0] fills_q;
    logic fill_ends, drain_ends;

    always_comb begin
        fill_ends  = hit && !rd_pop && (count == NEAR_FULL);
        drain_ends = rd_pop && (count == ONE_LEFT);
        state_d    = state_q;
        if (!cont_en) begin
            state_d = ST_WRAP;
        end else begin
            unique case (state_q)
                ST_WRAP:  state_d = ST_FILL;
                ST_FILL:  if (fill_ends) state_d = ST_DRAIN;
                ST_DRAIN: if (drain_ends)
                              state_d = (fills_q == LAST_FILL) ? ST_HALT : ST_FILL;
                ST_HALT:  state_d = ST_HALT;
                default:  state_d = ST_WRAP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WRAP;
            fills_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_WRAP) begin
                fills_q <= '0;
            end else if (state_q == ST_FILL && state_d == ST_DRAIN) begin
                fills_q <= fills_q + 1'b1;
            end
        end
    end

    always_comb begin
        push         = 1'b0;
        clear        = 1'b0;
        allow_over   = 1'b0;
        stall_req    = 1'b0;
        capture_done = 1'b0;
        unique case (state_q)
            ST_WRAP: begin
                clear      = cont_en;
                push       = hit && !cont_en;
                allow_over = 1'b1;
            end
            ST_FILL:  push = hit;
            ST_DRAIN: stall_req = 1'b1;
            ST_HALT:  capture_done = 1'b1;
            default:  push = 1'b0;
        endcase
    end
endmodule

// File: rtl/bt_trace_top.sv
module bt_trace_top #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8,
    parameter int FILLS  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       br_valid,
    input  logic [ADDR_W-1:0]          br_src,
    input  logic [ADDR_W-1:0]          br_dst,
    input  logic [1:0]                 br_kind,
    input  logic                       br_zero_disp,
    input  logic                       br_from_reset,
    input  logic                       keep_normal,
    input  logic                       keep_call,
    input  logic                       keep_exc,
    input  logic                       cont_en,
    input  logic                       rd_pop,
    output logic [ADDR_W-1:0]          rd_src,
    output logic [ADDR_W-1:0]          rd_dst,
    output logic [1:0]                 rd_kind,
    output logic [$clog2(DEPTH+1)-1:0] entry_count,
    output logic                       stall_req,
    output logic                       capture_done
);
    logic hit, push, clear, allow_over;

    bt_filter u_filter (
        .valid       (br_valid),
        .kind        (br_kind),
        .zero_disp   (br_zero_disp),
        .from_reset  (br_from_reset),
        .keep_normal (keep_normal),
        .keep_call   (keep_call),
        .keep_exc    (keep_exc),
        .hit         (hit)
    );

    bt_ctrl #(.DEPTH(DEPTH), .FILLS(FILLS)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cont_en      (cont_en),
        .hit          (hit),
        .rd_pop       (rd_pop),
        .count        (entry_count),
        .push         (push),
        .clear        (clear),
        .allow_over   (allow_over),
        .stall_req    (stall_req),
        .capture_done (capture_done)
    );

    bt_ring #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .push       (push),
        .pop        (rd_pop),
        .allow_over (allow_over),
        .wr_src     (br_src),
        .wr_dst     (br_dst),
        .wr_kind    (br_kind),
        .rd_src     (rd_src),
        .rd_dst     (rd_dst),
        .rd_kind    (rd_kind),
        .count      (entry_count)
    );
endmodule

// File: rtl/bt_trace_chk.sv
module bt_trace_chk #(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       br_valid,
    input logic                       br_zero_disp,
    input logic                       br_from_reset,
    input logic                       cont_en,
    input logic                       rd_pop,
    input logic [$clog2(DEPTH+1)-1:0] entry_count,
    input logic                       stall_req,
    input logic                       capture_done
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        entry_count <= FULL_CNT);

    assert_full_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_count == FULL_CNT && !rd_pop && !cont_en) |=> entry_count == FULL_CNT);

    assert_zero_disp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cont_en && !rd_pop && (!br_valid || br_zero_disp)) |=> $stable(entry_count));

    assert_reset_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cont_en && !rd_pop && br_from_reset) |=> $stable(entry_count));

    assert_stall_cont_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> $past(cont_en));

    assert_stall_rise_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_req) |-> entry_count == FULL_CNT);

    assert_stall_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> entry_count != '0);

    assert_halt_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_done && $past(capture_done) && !$past(rd_pop)) |-> $stable(entry_count));

    assert_halt_no_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        capture_done |-> !stall_req);
endmodule

bind bt_trace_top bt_trace_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .br_valid      (br_valid),
    .br_zero_disp  (br_zero_disp),
    .br_from_reset (br_from_reset),
    .cont_en       (cont_en),
    .rd_pop        (rd_pop),
    .entry_count   (entry_count),
    .stall_req     (stall_req),
    .capture_done  (capture_done)
);

// File: tb/bt_trace_top_bench.sv
module bt_trace_top_bench;
    localparam int AW    = 32;
    localparam int DEPTH = 8;
    localparam int FILLS = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          br_valid = 1'b0, br_zero_disp = 1'b0, br_from_reset = 1'b0;
    logic [AW-1:0] br_src = '0, br_dst = '0;
    logic [1:0]    br_kind = '0;
    logic          keep_normal = 1'b1, keep_call = 1'b1, keep_exc = 1'b1;
    logic          cont_en = 1'b0, rd_pop = 1'b0;
    logic [AW-1:0] rd_src, rd_dst;
    logic [1:0]    rd_kind;
    logic [CW-1:0] entry_count;
    logic          stall_req, capture_done;

    bt_trace_top #(.ADDR_W(AW), .DEPTH(DEPTH), .FILLS(FILLS)) u_bt_trace_top (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_src(br_src), .br_dst(br_dst),
        .br_kind(br_kind), .br_zero_disp(br_zero_disp), .br_from_reset(br_from_reset),
        .keep_normal(keep_normal), .keep_call(keep_call), .keep_exc(keep_exc),
        .cont_en(cont_en), .rd_pop(rd_pop), .rd_src(rd_src), .rd_dst(rd_dst),
        .rd_kind(rd_kind), .entry_count(entry_count), .stall_req(stall_req),
        .capture_done(capture_done)
    );

    int checks = 0;
    int bad = 0;
    int serial = 0;
    logic [AW-1:0] m_src[$];
    logic [AW-1:0] m_dst[$];
    logic [1:0]    m_kind[$];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_add(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [1:0] k);
        if (m_src.size() == DEPTH) begin
            void'(m_src.pop_front());
            void'(m_dst.pop_front());
            void'(m_kind.pop_front());
        end
        m_src.push_back(s);
        m_dst.push_back(d);
        m_kind.push_back(k);
    endtask

    task automatic model_clear();
        m_src.delete();
        m_dst.delete();
        m_kind.delete();
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // presents one branch for one cycle; returns its addresses
    task automatic send(input logic [1:0] k, input logic zd, input logic rs,
                        output logic [AW-1:0] s, output logic [AW-1:0] d);
        serial++;
        s = 32'h8000_0000 + AW'(serial) * 32'd16;
        d = 32'h0C00_0000 ^ (AW'(serial) * 32'd8);
        br_valid = 1'b1; br_src = s; br_dst = d; br_kind = k;
        br_zero_disp = zd; br_from_reset = rs;
        tick();
        br_valid = 1'b0; br_zero_disp = 1'b0; br_from_reset = 1'b0;
    endtask

    task automatic pop_one(input string req);
        check({req, " src"}, 64'(rd_src), 64'(m_src[0]));
        check({req, " dst"}, 64'(rd_dst), 64'(m_dst[0]));
        check({req, " kind"}, 64'(rd_kind), 64'(m_kind[0]));
        rd_pop = 1'b1;
        tick();
        rd_pop = 1'b0;
        void'(m_src.pop_front());
        void'(m_dst.pop_front());
        void'(m_kind.pop_front());
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [AW-1:0] s, d;
        logic          rec;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        check("R6 reset count", 64'(entry_count), 64'd0);
        check("R6 reset stall", 64'(stall_req), 64'd0);
        check("R6 reset done", 64'(capture_done), 64'd0);

        // filter sweep: every mask x kind x drop flags (R2, R3, R4), then ordered drain (R1)
        for (int mask = 0; mask < 8; mask++) begin
            keep_normal = mask[0]; keep_call = mask[1]; keep_exc = mask[2];
            for (int k = 0; k < 4; k++) begin
                for (int zd = 0; zd < 2; zd++) begin
                    for (int rs = 0; rs < 2; rs++) begin
                        rec = (k != 3) && mask[k] && (zd == 0) && (rs == 0);
                        send(2'(k), 1'(zd), 1'(rs), s, d);
                        if (rec) model_add(s, d, 2'(k));
                        if (zd != 0)      check("R3 zero displacement", 64'(entry_count), 64'(m_src.size()));
                        else if (rs != 0) check("R4 reset jump", 64'(entry_count), 64'(m_src.size()));
                        else              check("R2 kind filter", 64'(entry_count), 64'(m_src.size()));
                    end
                end
            end
            while (m_src.size() > 0) pop_one("R1 oldest first");
            check("R1 drained", 64'(entry_count), 64'd0);
        end

        // overwrite of oldest in WRAP (R5)
        keep_normal = 1'b1; keep_call = 1'b1; keep_exc = 1'b1;
        for (int i = 0; i < 13; i++) begin
            send(2'(i % 3), 1'b0, 1'b0, s, d);
            model_add(s, d, 2'(i % 3));
        end
        check("R5 count stays full", 64'(entry_count), 64'(DEPTH));
        while (m_src.size() > 0) pop_one("R5 oldest overwritten");

        // leave something behind, then enter continuous mode with a branch present (R7)
        for (int i = 0; i < 3; i++) begin
            send(2'd0, 1'b0, 1'b0, s, d);
        end
        cont_en = 1'b1;
        send(2'd1, 1'b0, 1'b0, s, d);
        model_clear();
        check("R7 cleared on entry", 64'(entry_count), 64'd0);

        for (int f = 0; f < FILLS; f++) begin
            for (int i = 0; i < DEPTH; i++) begin
                check("R8 no stall before full", 64'(stall_req), 64'd0);
                send(2'(i % 3), 1'b0, 1'b0, s, d);
                model_add(s, d, 2'(i % 3));
            end
            check("R8 stall on eighth", 64'(stall_req), 64'd1);
            send(2'd0, 1'b0, 1'b0, s, d);
            check("R8 ignored while stalled", 64'(entry_count), 64'(DEPTH));
            for (int i = 0; i < DEPTH - 1; i++) pop_one("R1 drain order");
            check("R9 stall held until empty", 64'(stall_req), 64'd1);
            pop_one("R1 drain last");
            check("R9 stall released", 64'(stall_req), 64'd0);
            check("R10 done after fourth", 64'(capture_done), 64'(f == FILLS - 1));
        end
        send(2'd0, 1'b0, 1'b0, s, d);
        check("R10 no record when done", 64'(entry_count), 64'd0);
        check("R10 no stall when done", 64'(stall_req), 64'd0);

        // back to WRAP (R11)
        cont_en = 1'b0;
        tick();
        check("R11 done cleared", 64'(capture_done), 64'd0);
        send(2'd2, 1'b0, 1'b0, s, d);
        model_add(s, d, 2'd2);
        check("R11 records again", 64'(entry_count), 64'd1);
        pop_one("R11 readout");

        // re-enter continuous mode: a fresh first fill must stall and not halt (R11)
        cont_en = 1'b1;
        tick();
        for (int i = 0; i < DEPTH; i++) begin
            send(2'd0, 1'b0, 1'b0, s, d);
            model_add(s, d, 2'd0);
        end
        check("R11 new session stalls", 64'(stall_req), 64'd1);
        while (m_src.size() > 0) pop_one("R11 new session order");
        check("R11 new session not done", 64'(capture_done), 64'd0);
        cont_en = 1'b0;
        tick();
        finish_run();
    end
endmodule